// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a double-precision fused multiply-add unit that computes Z + X×Y, or Z − X×Y when the negate input is set. A separate classifier has already sorted each operand into one of six classes. The resolver reads those classes, the three sign bits and the raw operand words. In the same cycle it decides whether the answer is fixed by the special operands or whether the arithmetic datapath has to run.

When the answer is fixed, the block also produces the final 64-bit word. That word is one of the following: a chosen operand, which is quieted if it was a signaling NaN; a parameterised default NaN; or a signed infinity. It reports the choice as a one-hot select code, together with flags for invalid operation, NaN quieting and compute enable. The block is purely combinational.

Top module: `fma_special_resolver`

## Requirements
- R1: The class inputs use this encoding: 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signaling NaN. The select code is one-hot. Bit 0 picks X, bit 1 picks Y, bit 2 picks Z, bit 3 picks the default NaN, bit 4 picks infinity and bit 5 picks compute. Exactly one bit is set for every combination of class codes 0 to 5, and the bypass-valid output is the inverse of bit 5.
- R2: A signaling-NaN Z outranks every X and Y class. It selects Z, raises invalid and asserts the quiet flag.
- R3: A signaling-NaN Y, when X is not a signaling NaN, selects Y. Otherwise a signaling-NaN X selects X. Both cases raise invalid and assert the quiet flag.
- R4: When no signaling NaN is present, a quiet-NaN Y with a non-NaN X selects Y. Otherwise a quiet-NaN X selects X. Neither case raises invalid or quiets, and both outrank a quiet-NaN Z.
- R5: Infinity times zero, in either order, selects Z when Z is a quiet NaN. Otherwise it selects the default NaN, which is exactly the DEF_NAN parameter (7FF8000000000000 hex by default), and raises invalid.
- R6: Infinity times an infinity or a nonzero finite value selects Z when Z is a quiet NaN. Otherwise it selects infinity with sign X.sign XOR Y.sign XOR negate. This holds whatever Z is, including an infinity of either sign.
- R7: A zero product (a zero factor and a finite other factor) selects infinity with Z's sign when Z is infinite. Otherwise it selects Z unchanged.
- R8: With both factors finite and nonzero, a quiet-NaN Z selects Z, an infinite Z selects infinity with Z's sign, and any other Z asserts compute enable with a result word of zero.
- R9: A quieted result is the chosen operand with fraction bit 51 forced to 1 and every other bit unchanged. An infinity result is the sign bit, eleven exponent ones and a zero fraction.
- R10: The negate input changes only the sign of an infinity that comes from the product. It has no effect on any select code or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| negProduct | input | 1 | Negate the product (Z − X×Y) |
| xClass | input | 3 | Class code of X |
| yClass | input | 3 | Class code of Y |
| zClass | input | 3 | Class code of the addend Z |
| xOp | input | 64 | Raw X word (sign in bit 63) |
| yOp | input | 64 | Raw Y word (sign in bit 63) |
| zOp | input | 64 | Raw Z word (sign in bit 63) |
| bypassValid | output | 1 | Result is fixed; datapath not needed |
| selCode | output | 6 | One-hot selection code |
| infSign | output | 1 | Sign of the infinity result |
| quietNan | output | 1 | Chosen NaN was quieted |
| invalidOp | output | 1 | Invalid-operation exception |
| computeEn | output | 1 | Arithmetic datapath must run |
| result | output | 64 | Bypass result word (zero when computing) |

## Verification
Quieting a signaling NaN and raising invalid happen in the same evaluation, and so do NaN priority and the infinity rules. The bench provokes these overlaps by driving signaling NaNs in several operands at once, and by pairing quiet-NaN addends with infinity-times-zero products. It judges the select code, both flags and the exact result word against an independent priority model. Long random runs over all six classes and both negate settings cover every operand-pair combination.

// File: rtl/fmaResolvePkg.sv
package fmaResolvePkg;

  localparam logic [2:0] CLS_ZERO   = 3'd0;
  localparam logic [2:0] CLS_NORM   = 3'd1;
  localparam logic [2:0] CLS_DENORM = 3'd2;
  localparam logic [2:0] CLS_INF    = 3'd3;
  localparam logic [2:0] CLS_QNAN   = 3'd4;
  localparam logic [2:0] CLS_SNAN   = 3'd5;

  localparam int SEL_W = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic pickX;
    logic pickY;
    logic pickZ;
    logic pickDefNan;
    logic pickInf;
    logic computeGo;
    logic infNeg;
    logic quietIt;
  } pathCtl_t;

endpackage

// File: rtl/fma_special_ctrl.sv
module fma_special_ctrl
  import fmaResolvePkg::*;
(
  input  logic       negProduct,
  input  logic [2:0] xCls,
  input  logic [2:0] yCls,
  input  logic [2:0] zCls,
  input  logic       xSign,
  input  logic       ySign,
  input  logic       zSign,
  output pathCtl_t   ctl,
  output logic       invalidOp
);

  logic xSnan, ySnan, zSnan, xQnan, yQnan, zQnan;
  logic xZero, yZero, xInf, yInf, zInf;
  logic prodSign;

  always_comb begin
    xSnan = (xCls == CLS_SNAN);
    ySnan = (yCls == CLS_SNAN);
    zSnan = (zCls == CLS_SNAN);
    xQnan = (xCls == CLS_QNAN);
    yQnan = (yCls == CLS_QNAN);
    zQnan = (zCls == CLS_QNAN);
    xZero = (xCls == CLS_ZERO);
    yZero = (yCls == CLS_ZERO);
    xInf  = (xCls == CLS_INF);
    yInf  = (yCls == CLS_INF);
    zInf  = (zCls == CLS_INF);
    prodSign = xSign ^ ySign ^ negProduct;
  end

  always_comb begin
    ctl = '0;
    invalidOp = 1'b0;
    if (zSnan) begin
      ctl.pickZ = 1'b1; ctl.quietIt = 1'b1; invalidOp = 1'b1;
    end else if (ySnan && !xSnan) begin
      ctl.pickY = 1'b1; ctl.quietIt = 1'b1; invalidOp = 1'b1;
    end else if (xSnan) begin
      ctl.pickX = 1'b1; ctl.quietIt = 1'b1; invalidOp = 1'b1;
    end else if (yQnan && !xQnan) begin
      ctl.pickY = 1'b1;
    end else if (xQnan) begin
      ctl.pickX = 1'b1;
    end else if ((xInf && yZero) || (xZero && yInf)) begin
      if (zQnan) ctl.pickZ = 1'b1;
      else begin
        ctl.pickDefNan = 1'b1; invalidOp = 1'b1;
      end
    end else if (xInf || yInf) begin
      if (zQnan) ctl.pickZ = 1'b1;
      else begin
        ctl.pickInf = 1'b1; ctl.infNeg = prodSign;
      end
    end else if (xZero || yZero) begin
      if (zInf) begin
        ctl.pickInf = 1'b1; ctl.infNeg = zSign;
      end else ctl.pickZ = 1'b1;
    end else begin
      if (zQnan) ctl.pickZ = 1'b1;
      else if (zInf) begin
        ctl.pickInf = 1'b1; ctl.infNeg = zSign;
      end else ctl.computeGo = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown({xCls, yCls, zCls})) begin
      // R1: exactly one selection
      a_r1_onehot_select: assert ($countones({ctl.pickX, ctl.pickY, ctl.pickZ,
          ctl.pickDefNan, ctl.pickInf, ctl.computeGo}) == 1)
        else $error("select not one-hot");
      // R2/R3: quieting only ever applies to an operand pick
      a_r3_quiet_needs_operand: assert (!ctl.quietIt || ctl.pickX || ctl.pickY || ctl.pickZ)
        else $error("quiet without operand");
      // R8: invalid never coincides with compute
      a_r8_invalid_no_compute: assert (!(invalidOp && ctl.computeGo))
        else $error("invalid while computing");
      // R2: signaling NaN addend always wins
      a_r2_znan_first: assert (!zSnan || (ctl.pickZ && invalidOp))
        else $error("signaling Z not first");
    end
  end

endmodule

// File: rtl/fma_special_dp.sv
module fma_special_dp
  import fmaResolvePkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [1+EXP_W+FRAC_W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
  input  pathCtl_t                       ctl,
  input  logic [1+EXP_W+FRAC_W-1:0]      xOp,
  input  logic [1+EXP_W+FRAC_W-1:0]      yOp,
  input  logic [1+EXP_W+FRAC_W-1:0]      zOp,
  output logic [1+EXP_W+FRAC_W-1:0]      result
);

  localparam int WIDTH = 1 + EXP_W + FRAC_W;
  localparam int QBIT  = FRAC_W - 1;

  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] pickedQ;
  logic [WIDTH-1:0] infWord;

  always_comb begin
    if (ctl.pickX)      picked = xOp;
    else if (ctl.pickY) picked = yOp;
    else                picked = zOp;
    pickedQ = picked;
    if (ctl.quietIt) pickedQ[QBIT] = 1'b1;
    infWord = {ctl.infNeg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  end

  always_comb begin
    result = '0;
    if (ctl.pickX || ctl.pickY || ctl.pickZ) result = pickedQ;
    else if (ctl.pickDefNan)                 result = DEF_NAN;
    else if (ctl.pickInf)                    result = infWord;
  end

  always_comb begin
    if (!$isunknown(ctl)) begin
      // R9: quieted word keeps payload except the quiet bit
      a_r9_quiet_payload: assert (!(ctl.quietIt && ctl.pickZ) ||
          (result[QBIT] && result[WIDTH-1:QBIT+1] == zOp[WIDTH-1:QBIT+1]
           && result[QBIT-1:0] == zOp[QBIT-1:0]))
        else $error("quiet payload altered");
      // R8: compute leaves the bypass word at zero
      a_r8_compute_zero: assert (!ctl.computeGo || result == '0)
        else $error("nonzero word while computing");
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fmaResolvePkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [1+EXP_W+FRAC_W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
  input  logic                          negProduct,
  input  logic [2:0]                    xClass,
  input  logic [2:0]                    yClass,
  input  logic [2:0]                    zClass,
  input  logic [1+EXP_W+FRAC_W-1:0]     xOp,
  input  logic [1+EXP_W+FRAC_W-1:0]     yOp,
  input  logic [1+EXP_W+FRAC_W-1:0]     zOp,
  output logic                          bypassValid,
  output logic [5:0]                    selCode,
  output logic                          infSign,
  output logic                          quietNan,
  output logic                          invalidOp,
  output logic                          computeEn,
  output logic [1+EXP_W+FRAC_W-1:0]     result
);

  localparam int WIDTH = 1 + EXP_W + FRAC_W;

  pathCtl_t ctl;

  fma_special_ctrl i_ctrl (
    .negProduct (negProduct),
    .xCls       (xClass),
    .yCls       (yClass),
    .zCls       (zClass),
    .xSign      (xOp[WIDTH-1]),
    .ySign      (yOp[WIDTH-1]),
    .zSign      (zOp[WIDTH-1]),
    .ctl        (ctl),
    .invalidOp  (invalidOp)
  );

  fma_special_dp #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .DEF_NAN (DEF_NAN)
  ) i_dp (
    .ctl    (ctl),
    .xOp    (xOp),
    .yOp    (yOp),
    .zOp    (zOp),
    .result (result)
  );

  assign selCode     = {ctl.computeGo, ctl.pickInf, ctl.pickDefNan,
                        ctl.pickZ, ctl.pickY, ctl.pickX};
  assign bypassValid = ~ctl.computeGo;
  assign computeEn   = ctl.computeGo;
  assign infSign     = ctl.infNeg;
  assign quietNan    = ctl.quietIt;

endmodule

// File: tb/test_fma_special_resolver.sv
`timescale 1ns/1ps
module test_fma_special_resolver;

  localparam logic [63:0] DEFNAN = 64'h7FF8_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        negProduct;
  logic [2:0]  xClass, yClass, zClass;
  logic [63:0] xOp, yOp, zOp;
  logic        bypassValid, infSign, quietNan, invalidOp, computeEn;
  logic [5:0]  selCode;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;

  fma_special_resolver i_fma_special_resolver (
    .negProduct(negProduct), .xClass(xClass), .yClass(yClass), .zClass(zClass),
    .xOp(xOp), .yOp(yOp), .zOp(zOp), .bypassValid(bypassValid),
    .selCode(selCode), .infSign(infSign), .quietNan(quietNan),
    .invalidOp(invalidOp), .computeEn(computeEn), .result(result)
  );

  task automatic refModel(input logic [2:0] xc, yc, zc, input logic xs, ys, zs, ng,
                          output logic [5:0] sel, output logic inv, q, isg,
                          output string req);
    sel = '0; inv = 0; q = 0; isg = 0; req = "R8";
    if (zc == 5) begin sel = 6'b000100; q = 1; inv = 1; req = "R2"; end
    else if (yc == 5 && xc != 5) begin sel = 6'b000010; q = 1; inv = 1; req = "R3"; end
    else if (xc == 5) begin sel = 6'b000001; q = 1; inv = 1; req = "R3"; end
    else if (yc == 4 && xc != 4) begin sel = 6'b000010; req = "R4"; end
    else if (xc == 4) begin sel = 6'b000001; req = "R4"; end
    else if ((xc == 3 && yc == 0) || (xc == 0 && yc == 3)) begin
      req = "R5";
      if (zc == 4) sel = 6'b000100;
      else begin sel = 6'b001000; inv = 1; end
    end else if (xc == 3 || yc == 3) begin
      req = "R6";
      if (zc == 4) sel = 6'b000100;
      else begin sel = 6'b010000; isg = xs ^ ys ^ ng; end
    end else if (xc == 0 || yc == 0) begin
      req = "R7";
      if (zc == 3) begin sel = 6'b010000; isg = zs; end
      else sel = 6'b000100;
    end else begin
      if (zc == 4) sel = 6'b000100;
      else if (zc == 3) begin sel = 6'b010000; isg = zs; end
      else sel = 6'b100000;
    end
  endtask

  function automatic logic [63:0] expWord(input logic [5:0] sel, input logic q, isg,
                                          input logic [63:0] x, y, z);
    logic [63:0] w;
    case (sel)
      6'b000001: w = x;
      6'b000010: w = y;
      6'b000100: w = z;
      6'b001000: return DEFNAN;
      6'b010000: return {isg, 11'h7FF, 52'd0};
      default:   return 64'd0;
    endcase
    if (q) w[51] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input logic [2:0] xc, yc, zc, input logic ng,
                        input logic [63:0] x, y, z, input string tag);
    logic [5:0] eSel; logic eInv, eQ, eIsg; string req;
    @(posedge clk);
    xClass = xc; yClass = yc; zClass = zc; negProduct = ng;
    xOp = x; yOp = y; zOp = z;
    refModel(xc, yc, zc, x[63], y[63], z[63], ng, eSel, eInv, eQ, eIsg, req);
    if (tag != "") req = tag;
    @(negedge clk);
    check(req, "selCode", {58'd0, selCode}, {58'd0, eSel});
    check(req, "invalidOp", {63'd0, invalidOp}, {63'd0, eInv});
    check(req, "quietNan", {63'd0, quietNan}, {63'd0, eQ});
    check(req, "result", result, expWord(eSel, eQ, eIsg, x, y, z));
    check("R1", "bypassValid", {63'd0, bypassValid}, {63'd0, ~eSel[5]});
    check("R8", "computeEn", {63'd0, computeEn}, {63'd0, eSel[5]});
    if (eSel[4]) check(req, "infSign", {63'd0, infSign}, {63'd0, eIsg});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    negProduct = 0; xClass = 0; yClass = 0; zClass = 0;
    xOp = '0; yOp = '0; zOp = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-like idle state: zero*zero+zero selects Z (R1, R7)
    @(negedge clk);
    check("R1", "idle selCode", {58'd0, selCode}, 64'd4);
    check("R7", "idle result", result, 64'd0);

    // directed corners
    runVec(5, 5, 5, 0, 64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0002,
           64'hFFF0_0000_0000_00AB, "R2");
    runVec(5, 5, 4, 0, 64'h7FF0_0000_0000_0011, 64'hFFF0_0000_0000_0022, 64'h7FF8_0000_0000_0033, "R3");
    runVec(1, 5, 4, 0, 64'h3FF0_0000_0000_0000, 64'hFFF0_1234_5678_9ABC, 64'h7FF8_0000_0000_0001, "R9");
    runVec(4, 4, 4, 0, 64'h7FF8_0000_0000_00AA, 64'h7FF8_0000_0000_00BB, 64'h7FF8_0000_0000_00CC, "R4");
    runVec(3, 0, 1, 0, 64'h7FF0_0000_0000_0000, 64'h0, 64'h3FF0_0000_0000_0000, "R5");
    runVec(0, 3, 4, 1, 64'h0, 64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0077, "R5");
    runVec(3, 1, 3, 0, 64'h7FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R6");
    runVec(3, 2, 3, 1, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hFFF0_0000_0000_0000, "R10");
    runVec(0, 1, 3, 1, 64'h0, 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R7");
    runVec(2, 0, 0, 1, 64'h0000_0000_0000_0005, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R7");
    runVec(1, 2, 3, 0, 64'h3FF0_0000_0000_0000, 64'h0000_0000_0000_0009, 64'hFFF0_0000_0000_0000, "R8");
    runVec(1, 1, 2, 1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h0000_0000_0000_0003, "R8");
    runVec(1, 1, 1, 1, 64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, "R10");

    // random sweep across all classes
    for (int i = 0; i < 4000; i++) begin
      runVec(3'($urandom_range(5, 0)), 3'($urandom_range(5, 0)), 3'($urandom_range(5, 0)),
             1'($urandom_range(1, 0)),
             {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule